// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block watches two ports of general-purpose input pins and records signal edges as pending interrupt events. Each pin has two enable bits, one for rising transitions and one for falling transitions, so a pin can interrupt on rising edges, on falling edges, or on both. The block records each enabled edge in its own sticky pending bit, one bit per pin for each edge direction. Software clears a pin's pending state by writing a one to that pin's bit in the port's clear location.

The pins are synchronized to the block clock with two flops. A third flop keeps the previous synchronized value, and an edge is the difference between the two. A read-only summary location has one bit per port. The interrupt output combines every pending bit of both ports with an external interrupt input, because all of them share one interrupt line. Registers are reached through a small synchronous write port and a combinational read port. Address bit 3 selects the port. Address bits 2:0 select the field.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset all enable and pending bits are zero, and `irq` equals `ext_irq`.
- R2: Field 0 (rise enable) and field 1 (fall enable) of each port are read-write, and a write is read back unchanged. Address bit 3 picks port A (0) or port B (1).
- R3: A 0-to-1 transition on a pin whose rise-enable bit is 1 sets that pin's bit in field 2 (rise pending) within 3 clock cycles.
- R4: A 1-to-0 transition on a pin whose fall-enable bit is 1 sets that pin's bit in field 3 (fall pending) within 3 clock cycles.
- R5: An edge on a pin whose enable bit for that direction is 0 never sets a pending bit.
- R6: A pending bit stays set, whatever the pin does, until it is cleared.
- R7: Writing to field 4 (clear) clears both the rise and fall pending bits of every pin written as 1. Pins written as 0 are unaffected, and field 4 reads as zero.
- R8: When an enabled edge is detected on a pin in the same cycle as a clear write to that pin, the new edge is recorded and its pending bit stays set.
- R9: Field 5 (summary, either port address) reads bit 0 as the OR of port A's pending bits and bit 1 as the OR of port B's pending bits. All other bits read as zero.
- R10: `irq` is 1 exactly when any pending bit of either port is set or `ext_irq` is 1.
- R11: Writes to the pending and summary fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 4 | Bit 3 selects the port, bits 2:0 select the field |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for `bus_addr`, combinational |
| pins_a | input | W | Port A pin levels, asynchronous |
| pins_b | input | W | Port B pin levels, asynchronous |
| ext_irq | input | 1 | External interrupt source that shares the line |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted synchronizer or previous-value flop shows up as a pending bit that is missing or appears spuriously. This becomes visible on `irq` and in the pending fields within three cycles of the pin change. A wrong clear mask or a wrong clear priority shows up in the first read after the clear write. The bench sweeps every pin of both ports in each edge direction and checks the exact one-hot pending pattern each time. This separates a wrong bit index or port swap from a correct design in the same cycle the bit is read.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [3:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pins_a,
  input  logic [W-1:0] pins_b,
  input  logic         ext_irq,
  output logic         irq
);
  localparam logic [2:0] F_REN = 3'd0, F_FEN = 3'd1, F_RPD = 3'd2,
                         F_FPD = 3'd3, F_CLR = 3'd4, F_SUM = 3'd5;

  logic [1:0][W-1:0] pin_in, s1, s2, prv, ren, fen, rpd, fpd;
  logic [1:0]        any_pd;
  logic [2:0]        fld;
  logic              sel;

  assign pin_in = {pins_b, pins_a};
  assign fld    = bus_addr[2:0];
  assign sel    = bus_addr[3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1  <= '0;
      s2  <= '0;
      prv <= '0;
    end else begin
      s1  <= pin_in;
      s2  <= s1;
      prv <= s2;
    end

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic          hit;
    logic [W-1:0]  clr, rise, fall;

    assign hit  = bus_wr && (sel == p[0]);
    assign clr  = (hit && fld == F_CLR) ? bus_wdata : '0;
    assign rise = s2[p] & ~prv[p] & ren[p];
    assign fall = ~s2[p] & prv[p] & fen[p];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ren[p] <= '0;
        fen[p] <= '0;
        rpd[p] <= '0;
        fpd[p] <= '0;
      end else begin
        if (hit && fld == F_REN) ren[p] <= bus_wdata;
        if (hit && fld == F_FEN) fen[p] <= bus_wdata;
        rpd[p] <= (rpd[p] & ~clr) | rise;
        fpd[p] <= (fpd[p] & ~clr) | fall;
      end

    assign any_pd[p] = |{rpd[p], fpd[p]};
  end

  always_comb
    case (fld)
      F_REN:   bus_rdata = ren[sel];
      F_FEN:   bus_rdata = fen[sel];
      F_RPD:   bus_rdata = rpd[sel];
      F_FPD:   bus_rdata = fpd[sel];
      F_SUM:   bus_rdata = W'(any_pd);
      default: bus_rdata = '0;
    endcase

  assign irq = ext_irq | (|any_pd);
endmodule

// File: rtl/gpio_edge_irq_sva.sv
module gpio_edge_irq_sva #(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [3:0]        bus_addr,
  input logic              ext_irq,
  input logic              irq,
  input logic [1:0][W-1:0] ren,
  input logic [1:0][W-1:0] fen,
  input logic [1:0][W-1:0] rpd,
  input logic [1:0][W-1:0] fpd
);
  p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ren == '0 && fen == '0 && rpd == '0 && fpd == '0));

  p_no_disabled_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rpd & ~$past(rpd) & ~$past(ren)) == '0 &&
              (fpd & ~$past(fpd) & ~$past(fen)) == '0));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr[2:0] == 3'd4) |=>
      ((rpd & $past(rpd)) == $past(rpd) && (fpd & $past(fpd)) == $past(fpd)));

  p_ext_shares_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq |-> irq);

  p_pend_raises_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rpd != '0 || fpd != '0) |-> irq);

  p_ro_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[2:0] >= 3'd2) |=> ($stable(ren) && $stable(fen)));
endmodule

bind gpio_edge_irq gpio_edge_irq_sva #(.W(W)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .ext_irq(ext_irq), .irq(irq), .ren(ren), .fen(fen), .rpd(rpd), .fpd(fpd)
);

// File: tb/gpio_edge_irq_test.sv
`timescale 1ns/1ps
module gpio_edge_irq_test;
  localparam int W = 32;
  logic clk = 0, rst_n = 0, bus_wr = 0, ext_irq = 0;
  logic [3:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, bus_rdata;
  logic [1:0][W-1:0] pins = '0;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_edge_irq #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_a(pins[0]),
    .pins_b(pins[1]), .ext_irq(ext_irq), .irq(irq)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [W-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [W-1:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [3:0] ad(int p, int f);
    return {p[0], f[2:0]};
  endfunction

  initial begin
    logic [W-1:0] v;
    idle(2); rst_n = 1; idle(1);

    for (int p = 0; p < 2; p++)
      for (int f = 0; f < 6; f++) begin
        rd(ad(p, f), v); check("R1 reset reg", v, '0);
      end
    check("R1 irq idle", W'(irq), 0);
    ext_irq = 1; #1; check("R10 ext drives irq", W'(irq), 1);
    ext_irq = 0; #1; check("R10 ext released", W'(irq), 0);

    wr(ad(0, 0), 32'hA5A5_1234); wr(ad(1, 1), 32'h0F0F_F0F0);
    rd(ad(0, 0), v); check("R2 rise en A", v, 32'hA5A5_1234);
    rd(ad(1, 1), v); check("R2 fall en B", v, 32'h0F0F_F0F0);
    rd(ad(1, 0), v); check("R2 rise en B untouched", v, '0);
    wr(ad(0, 2), '1); wr(ad(1, 3), '1); wr(ad(0, 5), '1);
    rd(ad(0, 2), v); check("R11 rise pend write ignored", v, '0);
    rd(ad(1, 3), v); check("R11 fall pend write ignored", v, '0);
    rd(ad(0, 5), v); check("R11 summary write ignored", v, '0);
    check("R11 irq quiet", W'(irq), 0);
    rd(ad(0, 0), v); check("R11 enables kept", v, 32'hA5A5_1234);

    for (int p = 0; p < 2; p++) begin
      wr(ad(p, 0), '1); wr(ad(p, 1), '0);
      for (int i = 0; i < W; i++) begin
        pins[p][i] = 1; idle(4);
        rd(ad(p, 2), v); check("R3 rise pend", v, W'(1) << i);
        rd(ad(0, 5), v); check("R9 summary", v, W'(1) << p);
        check("R10 irq pend", W'(irq), 1);
        pins[p][i] = 0; idle(4);
        rd(ad(p, 3), v); check("R5 fall disabled", v, '0);
        rd(ad(p, 2), v); check("R6 held after pin drop", v, W'(1) << i);
        wr(ad(p, 4), W'(1) << i);
        rd(ad(p, 2), v); check("R7 cleared", v, '0);
      end
      wr(ad(p, 0), '0); wr(ad(p, 1), '1);
      pins[p] = '1; idle(4);
      rd(ad(p, 2), v); check("R5 rise disabled", v, '0);
      check("R5 irq quiet", W'(irq), 0);
      for (int i = 0; i < W; i++) begin
        pins[p][i] = 0; idle(4);
        rd(ad(p, 3), v); check("R4 fall pend", v, W'(1) << i);
        rd(ad(1 - p, 3), v); check("R4 other port quiet", v, '0);
        wr(ad(p, 4), W'(1) << i);
        rd(ad(p, 3), v); check("R7 fall cleared", v, '0);
      end
      wr(ad(p, 1), '0);
    end

    wr(ad(0, 0), 32'h8); wr(ad(0, 1), 32'h8);
    pins[0][3] = 1; idle(4); pins[0][3] = 0; idle(4);
    rd(ad(0, 2), v); check("R3 both edges rise", v, 32'h8);
    rd(ad(0, 3), v); check("R4 both edges fall", v, 32'h8);
    idle(20);
    rd(ad(0, 2), v); check("R6 sticky", v, 32'h8);
    wr(ad(0, 4), 32'hFFFF_FFF7);
    rd(ad(0, 3), v); check("R7 zero bit keeps", v, 32'h8);
    rd(ad(0, 4), v); check("R7 clear reads zero", v, '0);
    wr(ad(0, 4), 32'h8);
    rd(ad(0, 2), v); check("R7 both cleared rise", v, '0);
    rd(ad(0, 3), v); check("R7 both cleared fall", v, '0);
    check("R10 irq drops", W'(irq), 0);

    wr(ad(0, 0), 32'h20); wr(ad(0, 1), 32'h20);
    pins[0][5] = 1; idle(4);
    pins[0][5] = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_addr = ad(0, 4); bus_wdata = 32'h20; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    rd(ad(0, 3), v); check("R8 edge beats clear", v, 32'h20);
    rd(ad(0, 2), v); check("R8 old rise cleared", v, '0);
    rd(ad(1, 5), v); check("R9 summary port A", v, 32'h1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule